// File: doc/BRIEF.md
# Smart-Card Bit Clock Generator

This block derives all bit timing for an ISO-7816-style smart card serial link from the peripheral clock. A prescaler divides by 1, 4, 16 or 64, picked by a two-bit select. An (N+1) divider follows it and sets the length of each half of the card clock. A counter of card clock periods then marks every elementary time unit (one bit). The transmit/receive shifter uses a one-cycle bit strobe and a mid-bit sample strobe. The card clock pin can be driven from the same chain, so the card clock is always an exact multiple of the bit rate.

With the default of 372 card clock periods per bit, one bit lasts 744 × 4^n × (N+1) peripheral clocks, where n is the prescale exponent. The divider and prescale settings are sampled only at a bit boundary. A rewrite in the middle of a bit therefore leaves the current bit and its card clock pulses at full length. There is no external clock input: timing always comes from the internal chain.

Top module: `sc_bitclk_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all counters clear and `bit_tick_o`, `mid_tick_o` and `card_clk_o` are low after that edge. The divider and prescale inputs are captured during reset.
- R2: `bit_tick_o` is a one-cycle pulse. Its period is P = 2 × ETU_CLKS × 4^n × (N+1) clock cycles. The first pulse comes P edges after the first edge with `rst_n` high.
- R3: The two-bit `pre_sel_i` encodes the prescale exponent n directly: 0 divides by 1, 1 by 4, 2 by 16 and 3 by 64.
- R4: `div_n_i` is an unsigned 8-bit N from 0 to 255, and it divides by N+1.
- R5: Each card clock period lasts 2 × 4^n × (N+1) cycles. Exactly ETU_CLKS card clock periods (372 by default) fall within each bit, and each bit boundary falls on a falling card clock edge.
- R6: `mid_tick_o` pulses once per bit, MID_CLK card clock periods after the bit boundary (period 186 of 372 by default). That is P/2 cycles after a bit strobe, and it never coincides with one.
- R7: While `clk_out_en_i` is low, `card_clk_o` is held low from the next cycle on. Both strobes keep their timing.
- R8: A change of `div_n_i` or `pre_sel_i` takes effect only for the bit that starts after the next bit boundary. The bit in progress keeps its length and mid-bit point.
- R9: Each high phase of the card clock lasts exactly 4^n × (N+1) cycles, so the high time within a bit totals ETU_CLKS × 4^n × (N+1) cycles and there is no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_n_i | input | DIV_W (8) | Divider value N |
| pre_sel_i | input | SEL_W (2) | Prescale exponent select |
| clk_out_en_i | input | 1 | Card clock pin enable |
| bit_tick_o | output | 1 | One-cycle strobe at each bit boundary |
| mid_tick_o | output | 1 | One-cycle strobe at the mid-bit sample point |
| card_clk_o | output | 1 | Card clock, low when disabled |

## Verification
The bench builds two copies that share the same stimulus. The default copy (372 periods per bit, sample at 186) checks the full bit length, the 372 rising card clock edges, the mid-bit point and mid-bit reconfiguration for small N and exponent. The second copy has two periods per bit and samples at period one. Its bits are 186 times shorter, which brings N = 255 with every prescale setting, up to 65,536 cycles per bit, within the run length. Its random draws of N and exponent are checked against the period formula.

// File: rtl/sc_clk_pkg.sv
package sc_clk_pkg;
    localparam int unsigned SC_DIV_W      = 8;
    localparam int unsigned SC_SEL_W      = 2;
    localparam int unsigned SC_ETU_DEF    = 372;
    localparam int unsigned SC_MID_DEF    = 186;
    localparam int unsigned SC_STEP_LOG2  = 2;   // each select step multiplies by 4

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = STEP_LOG2 * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;

    always_comb begin
        span   = (CNT_W+1)'(1) << (STEP_LOG2 * int'(sel_i));
        lim    = span[CNT_W-1:0] - CNT_W'(1);
        tick_o = (st_q.cnt == lim);
        st_d   = st_q;
        if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_half_divider.sv
module sc_half_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        tick_o = step_i && (st_q.cnt == '0);
        st_d   = st_q;
        if (step_i) begin
            if (tick_o) begin
                st_d.cnt = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= reload_i;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_etu_counter.sv
module sc_etu_counter
    import sc_clk_pkg::*;
#(
    parameter int unsigned ETU_CLKS = 372,
    parameter int unsigned MID_CLK  = 186
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_i,
    output logic phase_o,
    output logic phase_nxt_o,
    output logic wrap_o,
    output logic bit_tick_o,
    output logic mid_tick_o
);
    localparam int unsigned ETU_W = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
    localparam logic [ETU_W-1:0] LAST_IDX = ETU_W'(ETU_CLKS - 1);
    localparam logic [ETU_W-1:0] PRE_MID  = ETU_W'(MID_CLK - 1);

    typedef struct packed {
        phase_e           ph;
        logic [ETU_W-1:0] etu;
        logic             bit_tick;
        logic             mid_tick;
    } etu_st_t;

    etu_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.bit_tick = 1'b0;
        st_d.mid_tick = 1'b0;
        wrap_o        = half_i && (st_q.ph == PH_HIGH) && (st_q.etu == LAST_IDX);
        if (half_i) begin
            st_d.ph = (st_q.ph == PH_HIGH) ? PH_LOW : PH_HIGH;
            if (st_q.ph == PH_HIGH) begin
                if (st_q.etu == LAST_IDX) begin
                    st_d.etu      = '0;
                    st_d.bit_tick = 1'b1;
                end else begin
                    st_d.etu = st_q.etu + ETU_W'(1);
                end
                if (st_q.etu == PRE_MID) begin
                    st_d.mid_tick = 1'b1;
                end
            end
        end
        phase_nxt_o = (st_d.ph == PH_HIGH);
        phase_o     = (st_q.ph == PH_HIGH);
        bit_tick_o  = st_q.bit_tick;
        mid_tick_o  = st_q.mid_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_LOW, etu: '0, bit_tick: 1'b0, mid_tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_bitclk_gen.sv
module sc_bitclk_gen
    import sc_clk_pkg::*;
#(
    parameter int unsigned DIV_W     = SC_DIV_W,
    parameter int unsigned SEL_W     = SC_SEL_W,
    parameter int unsigned ETU_CLKS  = SC_ETU_DEF,
    parameter int unsigned MID_CLK   = SC_MID_DEF,
    parameter int unsigned STEP_LOG2 = SC_STEP_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n_i,
    input  logic [SEL_W-1:0] pre_sel_i,
    input  logic             clk_out_en_i,
    output logic             bit_tick_o,
    output logic             mid_tick_o,
    output logic             card_clk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             card_clk;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    pre_tick;
    logic    half_tick;
    logic    phase_q;
    logic    phase_nxt;
    logic    wrap;

    sc_prescaler #(
        .SEL_W     (SEL_W),
        .STEP_LOG2 (STEP_LOG2)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (st_q.sel),
        .tick_o (pre_tick)
    );

    sc_half_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (pre_tick),
        .reload_i (st_d.div),
        .tick_o   (half_tick)
    );

    sc_etu_counter #(
        .ETU_CLKS (ETU_CLKS),
        .MID_CLK  (MID_CLK)
    ) u_etu (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_i      (half_tick),
        .phase_o     (phase_q),
        .phase_nxt_o (phase_nxt),
        .wrap_o      (wrap),
        .bit_tick_o  (bit_tick_o),
        .mid_tick_o  (mid_tick_o)
    );

    always_comb begin
        st_d = st_q;
        if (wrap || !rst_n) begin
            st_d.div = div_n_i;
            st_d.sel = pre_sel_i;
        end
        st_d.card_clk = phase_nxt && clk_out_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div      <= div_n_i;
            st_q.sel      <= pre_sel_i;
            st_q.card_clk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_o = st_q.card_clk;
endmodule

// File: rtl/sc_bitclk_gen_chk.sv
module sc_bitclk_gen_chk #(
    parameter int unsigned ETU_CLKS = 372
) (
    input logic clk,
    input logic rst_n,
    input logic clk_out_en_i,
    input logic bit_tick_o,
    input logic mid_tick_o,
    input logic card_clk_o,
    input logic phase_i
);
    localparam int unsigned RC_W = $clog2(ETU_CLKS + 1);

    logic [RC_W-1:0] rise_cnt;
    logic            phase_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt   <= '0;
            phase_prev <= 1'b0;
        end else begin
            phase_prev <= phase_i;
            if (bit_tick_o) begin
                rise_cnt <= '0;
            end else if (phase_i && !phase_prev) begin
                rise_cnt <= rise_cnt + RC_W'(1);
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick_o && !mid_tick_o && !card_clk_o));

    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o);

    a_r5_rises_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> (rise_cnt == RC_W'(ETU_CLKS)));

    a_r6_mid_apart: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick_o |-> !bit_tick_o);

    a_r7_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_out_en_i |=> !card_clk_o);

    a_r9_boundary_low: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> !card_clk_o);
endmodule

bind sc_bitclk_gen sc_bitclk_gen_chk #(
    .ETU_CLKS (ETU_CLKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_out_en_i (clk_out_en_i),
    .bit_tick_o   (bit_tick_o),
    .mid_tick_o   (mid_tick_o),
    .card_clk_o   (card_clk_o),
    .phase_i      (phase_q)
);

// File: tb/test_sc_bitclk_gen.sv
`timescale 1ns/1ps
module test_sc_bitclk_gen;
    localparam int ETU_A = 372, MID_A = 186;
    localparam int ETU_B = 2,   MID_B = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_n = 8'd0;
    logic [1:0] sel = 2'd0;
    logic       en = 1'b1;
    logic       use_b = 1'b0;
    logic       tk_a, md_a, cc_a, tk_b, md_b, cc_b;
    logic       tk, md, cc;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         seed_val;

    always #5 clk = ~clk;

    sc_bitclk_gen i_sc_bitclk_gen (
        .clk(clk), .rst_n(rst_n), .div_n_i(div_n), .pre_sel_i(sel),
        .clk_out_en_i(en), .bit_tick_o(tk_a), .mid_tick_o(md_a), .card_clk_o(cc_a));

    sc_bitclk_gen #(.ETU_CLKS(ETU_B), .MID_CLK(MID_B)) i_sc_bitclk_gen_short (
        .clk(clk), .rst_n(rst_n), .div_n_i(div_n), .pre_sel_i(sel),
        .clk_out_en_i(en), .bit_tick_o(tk_b), .mid_tick_o(md_b), .card_clk_o(cc_b));

    assign tk = use_b ? tk_b : tk_a;
    assign md = use_b ? md_b : md_a;
    assign cc = use_b ? cc_b : cc_a;

    function automatic int half_len(input int n, input int nv);
        return (4 ** n) * (nv + 1);
    endfunction

    function automatic int etu_now();
        return use_b ? ETU_B : ETU_A;
    endfunction

    function automatic int mid_now();
        return use_b ? MID_B : MID_A;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int nv, input int n, input logic e);
        @(negedge clk);
        rst_n = 1'b0;
        div_n = nv[7:0];
        sel   = n[1:0];
        en    = e;
        repeat (2) @(negedge clk);
        chk("R1 outputs low in reset", int'({tk, md, cc}), 0);
        rst_n = 1'b1;
    endtask

    task automatic measure(input int chg_at, input int cn_v, input int cn_n,
                           output int per, output int rises, output int mid_at, output int hi);
        logic prev_cc;
        per = 0; rises = 0; mid_at = -1; hi = 0;
        prev_cc = cc;
        do begin
            if (per == chg_at) begin
                div_n = cn_v[7:0];
                sel   = cn_n[1:0];
            end
            @(posedge clk);
            per++;
            @(negedge clk);
            if (cc) hi++;
            if (cc && !prev_cc) rises++;
            prev_cc = cc;
            if (md && mid_at < 0) mid_at = per;
        end while (!tk && per < 200000);
    endtask

    task automatic judge(input int per, input int rises, input int mid_at, input int hi,
                         input int nv, input int n, input logic e);
        int h;
        h = half_len(n, nv);
        chk("R2/R3/R4 bit period", per, 2 * etu_now() * h);
        chk("R5 card clock rises per bit", rises, e ? etu_now() : 0);
        chk("R6 mid strobe offset", mid_at, 2 * mid_now() * h);
        chk("R9 high time per bit", hi, e ? etu_now() * h : 0);
    endtask

    task automatic run_cfg(input int nv, input int n, input logic e, input bit twice);
        int per, rises, mid_at, hi;
        do_reset(nv, n, e);
        measure(-1, 0, 0, per, rises, mid_at, hi);
        judge(per, rises, mid_at, hi, nv, n, e);
        if (twice) begin
            measure(-1, 0, 0, per, rises, mid_at, hi);
            judge(per, rises, mid_at, hi, nv, n, e);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int per, rises, mid_at, hi;
        seed_val = int'($urandom(32'h5C17));

        // default copy: 372 card clocks per bit
        use_b = 1'b0;
        run_cfg(0, 0, 1'b1, 1'b1);
        run_cfg(1, 0, 1'b1, 1'b1);
        run_cfg(0, 1, 1'b1, 1'b0);
        run_cfg(2, 0, 1'b1, 1'b0);
        // R7: pin disabled, strobes keep running
        run_cfg(0, 0, 1'b0, 1'b1);

        // R8: rewrite mid-bit, current bit keeps old length
        do_reset(0, 0, 1'b1);
        measure(-1, 0, 0, per, rises, mid_at, hi);
        measure(300, 1, 0, per, rises, mid_at, hi);
        chk("R8 bit in progress keeps old length", per, 744);
        chk("R8 mid point keeps old timing", mid_at, 372);
        measure(-1, 0, 0, per, rises, mid_at, hi);
        chk("R8 next bit uses new divider", per, 1488);
        chk("R5 rises after reconfiguration", rises, ETU_A);

        for (int k = 0; k < 3; k++) begin
            int rv;
            rv = int'($urandom_range(3, 0));
            run_cfg(rv, 0, 1'b1, 1'b0);
        end

        // short copy: 2 card clocks per bit, full N range
        use_b = 1'b1;
        for (int n = 0; n < 4; n++) begin
            run_cfg(255, n, 1'b1, 1'b0);
            run_cfg(0, n, 1'b1, 1'b1);
            run_cfg(1, n, 1'b1, 1'b0);
        end
        for (int k = 0; k < 6; k++) begin
            int rv, rn;
            rv = int'($urandom_range(15, 0));
            rn = int'($urandom_range(2, 0));
            run_cfg(rv, rn, ($urandom_range(1, 0) == 1), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule